// File: doc/BRIEF.md
# Masked Multi-Input Complex Beam Summer

The block adds complex samples from up to eight time-aligned input lanes into a single beam stream. Each lane carries a signed 16-bit real part, a signed 16-bit imaginary part and a valid bit. A runtime select mask picks which lanes take part in the sum. Bit `k` of the mask belongs to lane number `k+1`. Lanes that are not selected count as zero, and their valid bits do not matter.

The real and imaginary totals are formed at full width, then clamped to the 16-bit signed range. Any clamp on a valid result sets a sticky overflow flag. The flag stays set until an explicit clear strobe. The sum is pipelined with a fixed latency of three clocks, and the block accepts one new sample per clock.

Top module: `beam_summer`

## Requirements
- R1: While reset is asserted and right after it, `sum_valid` is 0, `sum_re` and `sum_im` are 0, and `ovf_flag` is 0.
- R2: Mask bit `k` selects lane number `k+1`, whose data sits at bits `[16k+15:16k]` of `lane_re` and `lane_im`. A lane whose mask bit is 0 adds zero to the sum, whatever data it presents.
- R3: When no part overflows, `sum_re` and `sum_im` are the exact signed sums of the real and imaginary parts of the selected lanes.
- R4: A result is marked valid only if every selected lane has its valid bit high in the same cycle. The valid bits of unselected lanes are ignored.
- R5: With an all-zero mask, every result is valid and both parts are zero.
- R6: Each part is summed at full width and then clamped independently. A total above 32767 gives 32767, and a total below -32768 gives -32768.
- R7: `ovf_flag` rises together with the valid result whose real or imaginary part was clamped. A total that lands exactly on 32767 or -32768 does not set it.
- R8: Once set, `ovf_flag` stays 1 until `ovf_clear` is sampled high, and it reads 0 on the next cycle. If a clamped result arrives on the same edge as the clear, the flag stays set.
- R9: In a cycle without a valid result, `sum_re` and `sum_im` keep their previous values and `ovf_flag` does not rise.
- R10: A sample presented in cycle `n` appears at the outputs in cycle `n+3`, and consecutive samples give consecutive results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lane_mask | input | 8 | Lane select; bit k selects lane number k+1 |
| lane_valid | input | 8 | Per-lane sample valid |
| lane_re | input | 128 | Per-lane signed real parts, lane k at [16k+15:16k] |
| lane_im | input | 128 | Per-lane signed imaginary parts, lane k at [16k+15:16k] |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| sum_valid | output | 1 | Beam result valid |
| sum_re | output | 16 | Clamped real sum |
| sum_im | output | 16 | Clamped imaginary sum |
| ovf_flag | output | 1 | Sticky overflow status |

## Verification
The summing path is driven with all eight lanes selected and small values, which checks the basic add. A sparse mask with large values on the unselected lanes shows whether deselected data leaks into the sum and whether the bit-to-lane mapping is right. A stream of distinct back-to-back samples separates a wrong pipeline depth from a wrong sum. Totals that exceed each rail, and totals that land exactly on a rail, separate correct clamping from an off-by-one limit and from a flag that fires on the boundary.

// File: rtl/bs_pkg.sv
package bs_pkg;
  localparam int unsigned BS_LANES_DEF = 8;
  localparam int unsigned BS_DW_DEF    = 16;
  localparam int unsigned BS_LATENCY   = 3;
endpackage

// File: rtl/bs_lane_gate.sv
module bs_lane_gate #(
  parameter int unsigned N_LANES = bs_pkg::BS_LANES_DEF,
  parameter int unsigned DW      = bs_pkg::BS_DW_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_LANES-1:0]      sel_mask,
  input  logic [N_LANES-1:0]      in_valid,
  input  logic [N_LANES*DW-1:0]   in_re,
  input  logic [N_LANES*DW-1:0]   in_im,
  output logic                    g_valid,
  output logic [N_LANES*DW-1:0]   g_re,
  output logic [N_LANES*DW-1:0]   g_im
);
  logic                  all_ok;
  logic [N_LANES*DW-1:0] re_nxt, im_nxt;
  logic [N_LANES*DW-1:0] re_q, im_q;
  logic                  v_q;

  assign all_ok = &(in_valid | ~sel_mask);

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    always_comb begin
      re_nxt[k*DW +: DW] = sel_mask[k] ? in_re[k*DW +: DW] : '0;
      im_nxt[k*DW +: DW] = sel_mask[k] ? in_im[k*DW +: DW] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      re_q <= '0;
      im_q <= '0;
    end else begin
      v_q <= all_ok;
      if (all_ok) begin
        re_q <= re_nxt;
        im_q <= im_nxt;
      end
    end
  end

  assign g_valid = v_q;
  assign g_re    = re_q;
  assign g_im    = im_q;
endmodule

// File: rtl/bs_sum_tree.sv
module bs_sum_tree #(
  parameter int unsigned N_LANES = bs_pkg::BS_LANES_DEF,
  parameter int unsigned DW      = bs_pkg::BS_DW_DEF,
  localparam int unsigned SW     = DW + $clog2(N_LANES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  g_valid,
  input  logic [N_LANES*DW-1:0] g_re,
  input  logic [N_LANES*DW-1:0] g_im,
  output logic                  t_valid,
  output logic [SW-1:0]         t_re,
  output logic [SW-1:0]         t_im
);
  logic [SW-1:0] acc_re, acc_im;
  logic [SW-1:0] re_q, im_q;
  logic          v_q;

  always_comb begin
    acc_re = '0;
    acc_im = '0;
    for (int k = 0; k < N_LANES; k++) begin
      acc_re = acc_re + {{(SW-DW){g_re[k*DW+DW-1]}}, g_re[k*DW +: DW]};
      acc_im = acc_im + {{(SW-DW){g_im[k*DW+DW-1]}}, g_im[k*DW +: DW]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      re_q <= '0;
      im_q <= '0;
    end else begin
      v_q <= g_valid;
      if (g_valid) begin
        re_q <= acc_re;
        im_q <= acc_im;
      end
    end
  end

  assign t_valid = v_q;
  assign t_re    = re_q;
  assign t_im    = im_q;
endmodule

// File: rtl/bs_clamp_out.sv
module bs_clamp_out #(
  parameter int unsigned N_LANES = bs_pkg::BS_LANES_DEF,
  parameter int unsigned DW      = bs_pkg::BS_DW_DEF,
  localparam int unsigned SW     = DW + $clog2(N_LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          t_valid,
  input  logic [SW-1:0] t_re,
  input  logic [SW-1:0] t_im,
  input  logic          clr,
  output logic          o_valid,
  output logic [DW-1:0] o_re,
  output logic [DW-1:0] o_im,
  output logic          o_ovf
);
  localparam logic signed [SW-1:0] MAXV = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic          hi_re, lo_re, hi_im, lo_im, clip;
  logic [DW-1:0] re_nxt, im_nxt;
  logic          ovf_nxt;
  logic [DW-1:0] re_q, im_q;
  logic          v_q, ovf_q;

  always_comb begin
    hi_re  = $signed(t_re) > MAXV;
    lo_re  = $signed(t_re) < MINV;
    hi_im  = $signed(t_im) > MAXV;
    lo_im  = $signed(t_im) < MINV;
    re_nxt = hi_re ? MAXV[DW-1:0] : (lo_re ? MINV[DW-1:0] : t_re[DW-1:0]);
    im_nxt = hi_im ? MAXV[DW-1:0] : (lo_im ? MINV[DW-1:0] : t_im[DW-1:0]);
    clip   = t_valid && (hi_re || lo_re || hi_im || lo_im);
    if (clip)     ovf_nxt = 1'b1;
    else if (clr) ovf_nxt = 1'b0;
    else          ovf_nxt = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      re_q  <= '0;
      im_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      v_q   <= t_valid;
      ovf_q <= ovf_nxt;
      if (t_valid) begin
        re_q <= re_nxt;
        im_q <= im_nxt;
      end
    end
  end

  assign o_valid = v_q;
  assign o_re    = re_q;
  assign o_im    = im_q;
  assign o_ovf   = ovf_q;
endmodule

// File: rtl/beam_summer.sv
module beam_summer #(
  parameter int unsigned N_LANES = bs_pkg::BS_LANES_DEF,
  parameter int unsigned DW      = bs_pkg::BS_DW_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_LANES-1:0]    lane_mask,
  input  logic [N_LANES-1:0]    lane_valid,
  input  logic [N_LANES*DW-1:0] lane_re,
  input  logic [N_LANES*DW-1:0] lane_im,
  input  logic                  ovf_clear,
  output logic                  sum_valid,
  output logic [DW-1:0]         sum_re,
  output logic [DW-1:0]         sum_im,
  output logic                  ovf_flag
);
  localparam int unsigned SW = DW + $clog2(N_LANES);

  logic [1:0]            rst_sync;
  logic                  rst_sync_n;
  logic                  g_valid, t_valid;
  logic [N_LANES*DW-1:0] g_re, g_im;
  logic [SW-1:0]         t_re, t_im;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  bs_lane_gate #(.N_LANES(N_LANES), .DW(DW)) u_gate (
    .clk(clk), .rst_n(rst_sync_n),
    .sel_mask(lane_mask), .in_valid(lane_valid),
    .in_re(lane_re), .in_im(lane_im),
    .g_valid(g_valid), .g_re(g_re), .g_im(g_im)
  );

  bs_sum_tree #(.N_LANES(N_LANES), .DW(DW)) u_tree (
    .clk(clk), .rst_n(rst_sync_n),
    .g_valid(g_valid), .g_re(g_re), .g_im(g_im),
    .t_valid(t_valid), .t_re(t_re), .t_im(t_im)
  );

  bs_clamp_out #(.N_LANES(N_LANES), .DW(DW)) u_clamp (
    .clk(clk), .rst_n(rst_sync_n),
    .t_valid(t_valid), .t_re(t_re), .t_im(t_im), .clr(ovf_clear),
    .o_valid(sum_valid), .o_re(sum_re), .o_im(sum_im), .o_ovf(ovf_flag)
  );
endmodule

// File: rtl/bs_checker.sv
module bs_checker #(
  parameter int unsigned N_LANES = 8,
  parameter int unsigned DW      = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [N_LANES-1:0]    lane_mask,
  input logic [N_LANES-1:0]    lane_valid,
  input logic                  ovf_clear,
  input logic                  sum_valid,
  input logic [DW-1:0]         sum_re,
  input logic [DW-1:0]         sum_im,
  input logic                  ovf_flag
);
  localparam logic [DW-1:0] TOP = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] BOT = {1'b1, {(DW-1){1'b0}}};

  logic [1:0] since;
  logic [1:0] zrun;
  logic       ok;
  logic       at_rail;

  assign ok      = &(lane_valid | ~lane_mask);
  assign at_rail = (sum_re == TOP) || (sum_re == BOT) || (sum_im == TOP) || (sum_im == BOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= 2'd0;
      zrun  <= 2'd0;
    end else begin
      if (since != 2'd3) since <= since + 2'd1;
      if (lane_mask != '0) zrun <= 2'd0;
      else if (zrun != 2'd3) zrun <= zrun + 2'd1;
    end
  end

  AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd3) |-> (sum_valid == $past(ok, 3)));                          // R4 R10
  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd3 && zrun == 2'd3) |-> (sum_valid && sum_re == '0 && sum_im == '0)); // R5
  AST_OVF_RISE_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (sum_valid && at_rail));                               // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clear) |=> ovf_flag);                                   // R8
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clear |=> (!ovf_flag || sum_valid));                                   // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_valid |-> ($stable(sum_re) && $stable(sum_im) && !$rose(ovf_flag)));  // R9
endmodule

bind beam_summer bs_checker #(.N_LANES(N_LANES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .lane_mask(lane_mask), .lane_valid(lane_valid), .ovf_clear(ovf_clear),
  .sum_valid(sum_valid), .sum_re(sum_re), .sum_im(sum_im), .ovf_flag(ovf_flag)
);

// File: tb/beam_summer_tb.sv
`timescale 1ns/1ps
module beam_summer_tb;
  localparam int N = 8;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   lane_mask, lane_valid;
  logic [N*W-1:0] lane_re, lane_im;
  logic           ovf_clear;
  logic           sum_valid, ovf_flag;
  logic [W-1:0]   sum_re, sum_im;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  int a_re [N];
  int a_im [N];
  int e_re, e_im;
  bit e_clip;

  always #2 clk = ~clk;

  beam_summer #(.N_LANES(N), .DW(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .lane_mask(lane_mask), .lane_valid(lane_valid),
    .lane_re(lane_re), .lane_im(lane_im), .ovf_clear(ovf_clear),
    .sum_valid(sum_valid), .sum_re(sum_re), .sum_im(sum_im), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampv(input int v, output bit c);
    c = 0;
    if (v > 32767)  begin c = 1; return 32767; end
    if (v < -32768) begin c = 1; return -32768; end
    return v;
  endfunction

  function automatic void model(input logic [N-1:0] m);
    int sr = 0, si = 0;
    bit c1, c2;
    for (int k = 0; k < N; k++) if (m[k]) begin sr += a_re[k]; si += a_im[k]; end
    e_re = clampv(sr, c1);
    e_im = clampv(si, c2);
    e_clip = c1 | c2;
  endfunction

  task automatic drive(input logic [N-1:0] m, input logic [N-1:0] v);
    lane_mask  = m;
    lane_valid = v;
    for (int k = 0; k < N; k++) begin
      lane_re[k*W +: W] = a_re[k][W-1:0];
      lane_im[k*W +: W] = a_im[k][W-1:0];
    end
  endtask

  task automatic fill(input int r0, input int rstep, input int i0, input int istep);
    for (int k = 0; k < N; k++) begin a_re[k] = r0 + rstep*k; a_im[k] = i0 + istep*k; end
  endtask

  task automatic wait_out();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic one_shot(input string tag, input logic [N-1:0] m, input logic [N-1:0] v);
    @(negedge clk);
    drive(m, v);
    model(m);
    wait_out();
    chk({tag, " valid"}, int'(sum_valid), 1);
    chk({tag, " re"}, int'($signed(sum_re)), e_re);
    chk({tag, " im"}, int'($signed(sum_im)), e_im);
    lane_valid = '0;
    lane_mask  = 8'hFF;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 valid", int'(sum_valid), 0);
    chk("R1 re", int'($signed(sum_re)), 0);
    chk("R1 im", int'($signed(sum_im)), 0);
    chk("R1 ovf", int'(ovf_flag), 0);
  endtask

  task automatic t_all_lanes();
    fill(10, 3, -7, 2);
    one_shot("R3 all", 8'hFF, 8'hFF);
    chk("R3 ovf", int'(ovf_flag), 0);
  endtask

  task automatic t_sparse_mask();
    fill(20000, 0, -20000, 0);
    a_re[0] = 5;   a_im[0] = -6;
    a_re[4] = 100; a_im[4] = 200;
    a_re[7] = -1;  a_im[7] = 9;
    one_shot("R2 sparse", 8'b1001_0001, 8'hFF);
    chk("R2 ovf", int'(ovf_flag), 0);
  endtask

  task automatic t_valid_rule();
    fill(1, 1, 2, 2);
    one_shot("R4 dis-invalid", 8'b0000_1111, 8'b0000_1111);
    @(negedge clk);
    drive(8'b0000_1111, 8'b1111_0111);
    wait_out();
    chk("R4 en-invalid valid", int'(sum_valid), 0);
    lane_valid = '0;
    @(negedge clk);
  endtask

  task automatic t_zero_mask();
    fill(9000, 1, -9000, 1);
    one_shot("R5 zero", 8'h00, 8'h00);
  endtask

  task automatic t_rail_exact();
    fill(0, 0, 0, 0);
    a_re[0] = 32000; a_re[1] = 767;
    a_im[2] = -32000; a_im[3] = -768;
    one_shot("R7 rail", 8'hFF, 8'hFF);
    chk("R7 rail no ovf", int'(ovf_flag), 0);
  endtask

  task automatic t_saturate();
    fill(30000, 0, -30000, 0);
    one_shot("R6 clamp", 8'hFF, 8'hFF);
    chk("R7 ovf set", int'(ovf_flag), 1);
    fill(1, 0, 1, 0);
    one_shot("R8 after", 8'h03, 8'h03);
    chk("R8 sticky", int'(ovf_flag), 1);
  endtask

  task automatic t_hold();
    int pr, pi;
    fill(3, 0, -4, 0);
    one_shot("R9 base", 8'h01, 8'h01);
    pr = int'($signed(sum_re));
    pi = int'($signed(sum_im));
    fill(30000, 0, 30000, 0);
    @(negedge clk);
    drive(8'hFF, 8'h7F);
    wait_out();
    chk("R9 no valid", int'(sum_valid), 0);
    chk("R9 hold re", int'($signed(sum_re)), pr);
    chk("R9 hold im", int'($signed(sum_im)), pi);
    chk("R9 no ovf", int'(ovf_flag), 0);
    lane_valid = '0;
    @(negedge clk);
  endtask

  task automatic t_clear();
    @(negedge clk);
    ovf_clear = 1'b1;
    @(negedge clk);
    ovf_clear = 1'b0;
    chk("R8 cleared", int'(ovf_flag), 0);
  endtask

  task automatic t_clear_race();
    fill(0, 0, -10000, 0);
    @(negedge clk);
    drive(8'hFF, 8'hFF);
    @(negedge clk);
    lane_valid = '0;
    @(negedge clk);
    ovf_clear = 1'b1;
    @(negedge clk);
    ovf_clear = 1'b0;
    chk("R8 set wins", int'(ovf_flag), 1);
    chk("R6 clamp low im", int'($signed(sum_im)), -32768);
  endtask

  task automatic t_stream();
    int xr [6];
    int xi [6];
    for (int s = 0; s < 9; s++) begin
      @(negedge clk);
      if (s >= 3) begin
        chk("R10 valid", int'(sum_valid), 1);
        chk("R10 re", int'($signed(sum_re)), xr[s-3]);
        chk("R10 im", int'($signed(sum_im)), xi[s-3]);
      end
      if (s < 6) begin
        fill(s*100, 1, -s*50, -1);
        drive(8'hFF, 8'hFF);
        model(8'hFF);
        xr[s] = e_re;
        xi[s] = e_im;
      end else begin
        lane_valid = '0;
      end
    end
    @(negedge clk);
    chk("R10 drained", int'(sum_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0; ovf_clear = 1'b0;
    lane_mask = 8'hFF; lane_valid = '0; lane_re = '0; lane_im = '0;
    repeat (4) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_all_lanes();
    t_sparse_mask();
    t_valid_rule();
    t_zero_mask();
    t_rail_exact();
    t_hold();
    t_saturate();
    t_clear();
    t_clear_race();
    t_clear();
    t_stream();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule